// File: doc/BRIEF.md
# Quad-Rate Burst-Four SRAM Port

This block models a static memory with separate read and write ports. Both ports move four-word double-data-rate bursts. A write or read starts on a main-clock rise when its active-low select is sampled low. The start address is latched on that rise. Write words then arrive on the next four half-cycle edges, starting one full cycle later. Read words leave on four consecutive half-cycle edges, starting one and a half cycles after the address.

Both clock edges are modelled with one internal clock at twice the main-clock rate. A phase bit marks which internal edge stands for the main-clock rise, and the `kRise` output exposes it. One data word is captured or driven per internal clock. A read and a write may start on the same rise. A request of the same kind on the rise that directly follows an accepted one is dropped. The read data bus is released to high impedance except during read beats, and `qOe` reports when it is driven.

Top module: `qdrBurstSram`

## Requirements
- R1: After reset `qOe` is low, `q` is high impedance, and `kRise` is high for the first internal cycle. `kRise` then alternates every internal cycle, and commands are sampled only on edges where it is high.
- R2: A write accepted on edge E stores the words on `d` at edges E+2, E+3, E+4 and E+5 into burst beats 0, 1, 2 and 3.
- R3: A read accepted on edge E drives burst beat b on `q` with `qOe` high during the internal cycle after edge E+3+b, for b from 0 to 3.
- R4: Burst beat b uses the address whose upper bits equal the start address and whose two lowest bits are the start's low bits plus b, modulo four.
- R5: When both selects are high on a main-clock rise, memory is unchanged, `d` is ignored, and no read beats are produced.
- R6: A read request on the main-clock rise directly after a rise that accepted a read is ignored.
- R7: A write request on the main-clock rise directly after a rise that accepted a write is ignored.
- R8: Select values on the half-cycle edges where `kRise` is low have no effect.
- R9: A read and a write accepted on the same rise to the same address return the data stored before that write.
- R10: A read accepted two main-clock rises after another read continues the data stream with no gap, so `qOe` stays high for eight beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the main-clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| kRise | output | 1 | High in internal cycles whose closing edge is a main-clock rise |
| rdSelN | input | 1 | Active-low read request |
| wrSelN | input | 1 | Active-low write request |
| addr | input | AW | Burst start address |
| d | input | DW | Write data, one word per internal clock |
| q | output | DW | Read data, high impedance when not driven |
| qOe | output | 1 | High while `q` carries a read beat |

## Verification
Every result is due a fixed number of internal edges after its command edge. Write beats land in memory on edges E+2 to E+5, and read beats appear after edges E+3 to E+6. The bench counts internal edges from reset and enqueues each expected read beat together with the edge after which it must appear. The reference memory applies only the write beats that land strictly before a read's command edge. A monitor samples on the falling edge. It requires the queued beat exactly in its due cycle and a released bus in every other cycle, so an early, late, missing or extra beat all fail.

// File: rtl/qbPkg.sv
package qbPkg;
  localparam int BURST  = 4;
  localparam int WR_LAT = 2;   // edges from command to first write beat
  localparam int RD_LAT = 3;   // edges from command to first read beat

  typedef struct packed {
    logic       rdTake;
    logic       rdSlot;
    logic       wrTake;
    logic       wrSlot;
    logic       wrEn;
    logic [1:0] wrBeat;
    logic       wrUseSlot;
    logic       outEn;
    logic [1:0] outBeat;
    logic       outUseSlot;
  } qbStrobe_t;
endpackage

// File: rtl/qbCtrl.sv
module qbCtrl
  import qbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdSelN,
  input  logic      wrSelN,
  output logic      kRise,
  output qbStrobe_t st
);
  localparam int RD_TOP = RD_LAT + BURST - 2;
  localparam int WR_TOP = WR_LAT + BURST - 2;
  localparam int K_GAP  = 1;   // history index of the previous main-clock rise

  logic              phase;
  logic              rdPtr, wrPtr;
  logic [RD_TOP:0]   rdHist, rdSlotHist;
  logic [WR_TOP:0]   wrHist, wrSlotHist;
  logic              rdTake, wrTake;

  assign kRise  = ~phase;
  assign rdTake = kRise & ~rdSelN & ~rdHist[K_GAP];
  assign wrTake = kRise & ~wrSelN & ~wrHist[K_GAP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= 1'b0;
      rdPtr      <= 1'b0;
      wrPtr      <= 1'b0;
      rdHist     <= '0;
      rdSlotHist <= '0;
      wrHist     <= '0;
      wrSlotHist <= '0;
    end else begin
      phase      <= ~phase;
      rdPtr      <= rdPtr ^ rdTake;
      wrPtr      <= wrPtr ^ wrTake;
      rdHist     <= {rdHist[RD_TOP-1:0], rdTake};
      rdSlotHist <= {rdSlotHist[RD_TOP-1:0], rdPtr};
      wrHist     <= {wrHist[WR_TOP-1:0], wrTake};
      wrSlotHist <= {wrSlotHist[WR_TOP-1:0], wrPtr};
    end
  end

  always_comb begin
    st            = '0;
    st.rdTake     = rdTake;
    st.rdSlot     = rdPtr;
    st.wrTake     = wrTake;
    st.wrSlot     = wrPtr;
    for (int b = 0; b < BURST; b++) begin
      if (rdHist[RD_LAT-1+b]) begin
        st.outEn      = 1'b1;
        st.outBeat    = 2'(b);
        st.outUseSlot = rdSlotHist[RD_LAT-1+b];
      end
      if (wrHist[WR_LAT-1+b]) begin
        st.wrEn      = 1'b1;
        st.wrBeat    = 2'(b);
        st.wrUseSlot = wrSlotHist[WR_LAT-1+b];
      end
    end
  end

  // R6
  rd_repeat_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdTake |-> ##2 !rdTake);
  // R7
  wr_repeat_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> ##2 !wrTake);
  // R10
  rd_beat_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdHist[RD_TOP:RD_LAT-1]));
  // R2
  wr_beat_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrHist[WR_TOP:WR_LAT-1]));
endmodule

// File: rtl/qbDatapath.sv
module qbDatapath
  import qbPkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  qbStrobe_t     st,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] qData,
  output logic          qOe
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 2;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] rdBuf  [SLOTS][BURST];
  logic [AW-1:0] wrBase [SLOTS];

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] base, input logic [1:0] beat);
    return {base[AW-1:2], 2'(base[1:0] + beat)};
  endfunction

  always_ff @(posedge clk) begin
    if (st.wrEn) mem[beatAddr(wrBase[st.wrUseSlot], st.wrBeat)] <= d;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (st.rdTake && st.rdSlot == 1'(s)) begin
        for (int b = 0; b < BURST; b++) rdBuf[s][b] <= mem[beatAddr(addr, 2'(b))];
      end
      if (st.wrTake && st.wrSlot == 1'(s)) wrBase[s] <= addr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qOe   <= 1'b0;
      qData <= '0;
    end else begin
      qOe <= st.outEn;
      if (st.outEn) qData <= rdBuf[st.outUseSlot][st.outBeat];
    end
  end

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rdTake |-> ##4 qOe);
  // R2
  wr_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrTake |-> ##2 (st.wrEn && st.wrBeat == 2'd0));
endmodule

// File: rtl/qdrBurstSram.sv
module qdrBurstSram
  import qbPkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  output logic          kRise,
  input  logic          rdSelN,
  input  logic          wrSelN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          qOe
);
  qbStrobe_t     st;
  logic [DW-1:0] qData;

  qbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .kRise(kRise), .st(st)
  );

  qbDatapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .addr(addr), .d(d),
    .qData(qData), .qOe(qOe)
  );

  assign q = qOe ? qData : {DW{1'bz}};
endmodule

// File: tb/qdrBurstSram_tb.sv
module qdrBurstSram_tb;
  localparam int AW = 6;
  localparam int DW = 16;

  typedef struct {
    int            e;
    logic [DW-1:0] v;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          kRise, qOe;
  logic          rdSelN = 1'b1, wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  wire  [DW-1:0] q;

  int            edgeCnt = 0;
  int            nChecks = 0, nFails = 0;
  bit            running = 1'b0;
  string         curReq = "R1";
  int            lastRd = -100, lastWr = -100;
  logic [DW-1:0] modelMem [1 << AW];
  exp_t          expQ [$];
  int            evE [$];
  logic [AW-1:0] evA [$];
  logic [DW-1:0] evD [$];

  qdrBurstSram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .kRise(kRise), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .addr(addr), .d(d), .q(q), .qOe(qOe)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  function automatic logic [DW-1:0] dataFor(int e);
    return DW'(e * 16'h3B1) ^ 16'hA5C3;
  endfunction

  function automatic logic [AW-1:0] wrapA(logic [AW-1:0] a, int b);
    return {a[AW-1:2], 2'(a[1:0] + 2'(b))};
  endfunction

  // write data is always a function of the edge index, so NOP cycles see it change
  always @(negedge clk) d <= dataFor(edgeCnt);

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", req, what, act, expv, edgeCnt);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && running) begin
      int last;
      last = edgeCnt - 1;
      while (expQ.size() > 0 && expQ[0].e < last) begin
        chk(1'b0, curReq, "read beat missing", '0, expQ[0].v);
        void'(expQ.pop_front());
      end
      if (expQ.size() > 0 && expQ[0].e == last) begin
        chk(qOe === 1'b1, "R3", "qOe during beat", DW'(qOe), 1);
        chk(q === expQ[0].v, curReq, "read beat data", q, expQ[0].v);
        void'(expQ.pop_front());
      end else begin
        chk(qOe === 1'b0, curReq, "bus released", DW'(qOe), 0);
      end
      chk(kRise === (edgeCnt % 2 == 0), "R8", "kRise phase", DW'(kRise), DW'(edgeCnt % 2 == 0));
    end
  end

  // driver: one main-clock cycle, starting at a negedge before a K-rise edge
  task automatic kcmd(input logic rdN, input logic wrN, input logic [AW-1:0] a,
                      input logic oddRd = 1'b1, input logic oddWr = 1'b1);
    int e;
    exp_t it;
    e = edgeCnt;
    rdSelN = rdN;
    wrSelN = wrN;
    addr   = a;
    if (!rdN && (e - lastRd != 2)) begin
      lastRd = e;
      while (evE.size() > 0 && evE[0] < e) begin
        modelMem[evA[0]] = evD[0];
        void'(evE.pop_front());
        void'(evA.pop_front());
        void'(evD.pop_front());
      end
      for (int b = 0; b < 4; b++) begin
        it.e = e + 3 + b;
        it.v = modelMem[wrapA(a, b)];
        expQ.push_back(it);
      end
    end
    if (!wrN && (e - lastWr != 2)) begin
      lastWr = e;
      for (int b = 0; b < 4; b++) begin
        evE.push_back(e + 2 + b);
        evA.push_back(wrapA(a, b));
        evD.push_back(dataFor(e + 2 + b));
      end
    end
    @(negedge clk);
    rdSelN = oddRd;
    wrSelN = oddWr;
    addr   = ~a;
    @(negedge clk);
    rdSelN = 1'b1;
    wrSelN = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) kcmd(1'b1, 1'b1, '0);
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishTest();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state before the first edge
    chk(qOe === 1'b0, "R1", "qOe after reset", DW'(qOe), 0);
    chk(kRise === 1'b1, "R1", "kRise after reset", DW'(kRise), 1);
    running = 1'b1;
    idle(2);

    // R2: fill 0..15 and 40..47 with write bursts
    curReq = "R2";
    for (int i = 0; i < 4; i++) begin kcmd(1'b1, 1'b0, AW'(4 * i)); idle(1); end
    kcmd(1'b1, 1'b0, 6'd40); idle(1);
    kcmd(1'b1, 1'b0, 6'd44); idle(2);

    // R3: single read and its latency
    curReq = "R3";
    kcmd(1'b0, 1'b1, 6'd4); idle(4);

    // R10: reads two rises apart stream without a gap
    curReq = "R10";
    kcmd(1'b0, 1'b1, 6'd0); idle(1);
    kcmd(1'b0, 1'b1, 6'd8); idle(4);

    // R6: read on the very next rise is dropped
    curReq = "R6";
    kcmd(1'b0, 1'b1, 6'd12);
    kcmd(1'b0, 1'b1, 6'd0); idle(4);

    // R4: start address with low bits 2 wraps within the aligned group
    curReq = "R4";
    kcmd(1'b1, 1'b0, 6'd6); idle(1);
    kcmd(1'b0, 1'b1, 6'd4); idle(3);
    kcmd(1'b0, 1'b1, 6'd4); idle(4);
    kcmd(1'b0, 1'b1, 6'd45); idle(4);

    // R7: write on the very next rise is dropped, address 12 keeps old data
    curReq = "R7";
    kcmd(1'b1, 1'b0, 6'd8);
    kcmd(1'b1, 1'b0, 6'd12); idle(3);
    kcmd(1'b0, 1'b1, 6'd12); idle(1);
    kcmd(1'b0, 1'b1, 6'd8); idle(4);

    // R9: read and write of the same address on one rise
    curReq = "R9";
    kcmd(1'b0, 1'b0, 6'd0); idle(3);
    kcmd(1'b0, 1'b1, 6'd0); idle(4);

    // R8: selects low only on the half-cycle edge
    curReq = "R8";
    kcmd(1'b1, 1'b1, 6'd12, 1'b0, 1'b0);
    kcmd(1'b1, 1'b1, 6'd4, 1'b0, 1'b0); idle(4);
    kcmd(1'b0, 1'b1, 6'd12); idle(1);
    kcmd(1'b0, 1'b1, 6'd4); idle(4);

    // R5: NOP cycles with changing data leave memory intact
    curReq = "R5";
    idle(6);
    kcmd(1'b0, 1'b1, 6'd40); idle(1);
    kcmd(1'b0, 1'b1, 6'd8); idle(1);
    kcmd(1'b0, 1'b0, 6'd12); idle(4);
    kcmd(1'b0, 1'b1, 6'd12); idle(6);

    chk(expQ.size() == 0, "R3", "scoreboard drained", DW'(expQ.size()), 0);
    finishTest();
  end
endmodule